// File: doc/BRIEF.md
# 9-Bit Address-Filtering Serial Transceiver

This block is a full-duplex asynchronous serial port that moves 11-bit characters. Each character has a low start bit, eight data bits sent least significant bit first, a ninth bit whose value the sender chooses, and a high stop bit. The bit time comes from a fixed divider of the core clock. The divider is 2×`DIV_BASE` core clocks by default. When `dbl_speed` is high it is `DIV_BASE` core clocks, which doubles the rate.

On the receive side the block can act as one station on a shared multidrop line. When `filt_en` is high, a character whose ninth bit is 1 is an address character. Every address character is delivered. The block compares it with `my_addr` under `addr_mask`, and a mask bit of 0 makes that address bit a don't-care. A match puts the block in the addressed state. In that state, characters whose ninth bit is 0 are delivered too, until the next address character re-decides the state. When `filt_en` is low, every well-framed character is delivered and the addressed state is cleared.

Top module: `mp9_uart`

## Requirements
- R1: `txd` idles at 1. A frame sent on `txd` is, in time order: one 0 start bit, `tx_data[0]` through `tx_data[7]`, the value of `tx_bit9` at load time, and one 1 stop bit.
- R2: Every transmitted bit holds for exactly 2×`DIV_BASE` clock cycles, or `DIV_BASE` cycles when `dbl_speed` is 1. The rate is captured when the frame starts. The receiver samples using the same bit time.
- R3: A `tx_load` pulse while idle starts a frame on the next clock edge. `tx_busy` stays high for exactly 11 bit times. A `tx_load` while `tx_busy` is high is ignored and leaves the frame in progress unchanged.
- R4: A received frame with a 1 stop bit that the filter passes makes `rx_valid` high for one cycle. On that cycle `rx_data` carries the eight data bits and `rx_bit9` carries the ninth bit. Both hold until the next delivered frame.
- R5: A received frame whose stop bit is 0 is discarded: no `rx_valid`, and `rx_data` and `rx_bit9` are unchanged.
- R6: With `filt_en` at 1 and the block not addressed, a frame whose ninth bit is 0 raises no `rx_valid` and leaves `rx_data` unchanged.
- R7: With `filt_en` at 1, a well-framed frame whose ninth bit is 1 is always delivered. After it, `addressed` is 1 exactly when ((data XOR `my_addr`) AND `addr_mask`) is zero, and 0 otherwise.
- R8: While `addressed` is 1, frames whose ninth bit is 0 are delivered.
- R9: `filt_en` at 0 forces `addressed` to 0 on the next clock edge. While `filt_en` is 0, every well-framed frame is delivered.
- R10: After reset: `txd` = 1, `tx_busy` = 0, `rx_valid` = 0, `rx_data` = 0, `rx_bit9` = 0, `addressed` = 0.
- R11: A low pulse on `rxd` that has ended by the middle of the start bit is rejected as a false start and delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbl_speed | input | 1 | 1 halves the bit time to DIV_BASE clocks |
| filt_en | input | 1 | Enables multidrop address filtering |
| my_addr | input | 8 | Station address |
| addr_mask | input | 8 | Address compare mask, 0 = don't care |
| tx_load | input | 1 | Start a transmit frame (ignored while busy) |
| tx_data | input | 8 | Transmit data byte |
| tx_bit9 | input | 1 | Transmit ninth bit |
| tx_busy | output | 1 | Transmit frame in progress |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle strobe for a delivered frame |
| rx_data | output | 8 | Last delivered data byte |
| rx_bit9 | output | 1 | Ninth bit of the last delivered frame |
| addressed | output | 1 | Station currently selected by an address frame |

## Verification
A wrong addressed state cannot be seen at `rx_valid` until a frame with a 0 ninth bit arrives. The bench therefore reads `addressed` after every address frame and then sends a data frame, so the error shows within one character time. A bad transmit shift or bit counter shows on `txd` at the first and last cycle of the affected bit, and a wrong divider shows at the first bit boundary. Receiver sampling errors show as a wrong `rx_data`, or as a missing or extra `rx_valid` pulse, within about two bit times after the stop bit.

// File: rtl/mp9_pkg.sv
package mp9_pkg;

  localparam int FRAME_BITS = 11;  // start + 8 data + ninth + stop
  localparam int RX_SAMPLES = 10;  // samples taken after the start bit

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_WAIT_HIGH
  } rx_state_e;

  // core clocks per serial bit
  function automatic int bit_period(int base, logic dbl);
    return dbl ? base : 2 * base;
  endfunction

  // masked station-address compare: a 0 in care ignores that bit
  function automatic logic addr_hit(logic [7:0] got, logic [7:0] own,
                                    logic [7:0] care);
    return ((got ^ own) & care) == 8'h00;
  endfunction

endpackage

// File: rtl/mp9_bit_timer.sv
module mp9_bit_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign expire = (cnt == '0);

endmodule

// File: rtl/mp9_tx.sv
module mp9_tx #(
  parameter int DIV_BASE = 32,
  parameter int CW       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbl,
  input  logic       load,
  input  logic [7:0] data,
  input  logic       bit9,
  output logic       busy,
  output logic       txd
);

  localparam logic [3:0] LAST_IDX = 4'(mp9_pkg::FRAME_BITS - 1);

  logic [10:0]   sh;
  logic [3:0]    idx;
  logic [CW-1:0] per_q;
  logic [CW-1:0] per_m1;
  logic          start;
  logic          expire;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;

  assign per_m1   = CW'(mp9_pkg::bit_period(DIV_BASE, dbl) - 1);
  assign start    = load & ~busy;
  assign tmr_load = start | (busy & expire & (idx != LAST_IDX));
  assign tmr_val  = start ? per_m1 : per_q;

  mp9_bit_timer #(.CW(CW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '1;
      idx   <= '0;
      busy  <= 1'b0;
      per_q <= '0;
    end else if (start) begin
      sh    <= {1'b1, bit9, data, 1'b0};
      idx   <= '0;
      busy  <= 1'b1;
      per_q <= per_m1;
    end else if (busy && expire) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
      end else begin
        sh  <= {1'b1, sh[10:1]};
        idx <= idx + 4'd1;
      end
    end
  end

  assign txd = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/mp9_rx.sv
module mp9_rx #(
  parameter int DIV_BASE = 32,
  parameter int CW       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbl,
  input  logic       rxd,
  output logic       frame_done,
  output logic [7:0] frame_data,
  output logic       frame_b9,
  output logic       frame_stop
);

  import mp9_pkg::*;

  localparam logic [3:0] LAST_IDX = 4'(RX_SAMPLES - 1);

  rx_state_e     state;
  logic [1:0]    sync;
  logic          rxd_s;
  logic [3:0]    idx;
  logic [9:0]    sh;
  logic [CW-1:0] per_q;
  logic [CW-1:0] per_m1;
  logic [CW-1:0] half_m1;
  logic          expire;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          done_q;

  assign per_m1  = CW'(bit_period(DIV_BASE, dbl) - 1);
  assign half_m1 = CW'(bit_period(DIV_BASE, dbl) / 2 - 1);
  assign rxd_s   = sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = per_q;
    unique case (state)
      RX_IDLE: begin
        tmr_load = ~rxd_s;
        tmr_val  = half_m1;
      end
      RX_START: tmr_load = expire & ~rxd_s;
      RX_BITS:  tmr_load = expire & (idx != LAST_IDX);
      default:  tmr_load = 1'b0;
    endcase
  end

  mp9_bit_timer #(.CW(CW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      idx    <= '0;
      sh     <= '0;
      per_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (!rxd_s) begin
            per_q <= per_m1;
            state <= RX_START;
          end
        end
        RX_START: begin
          if (expire) begin
            idx   <= '0;
            state <= rxd_s ? RX_IDLE : RX_BITS;
          end
        end
        RX_BITS: begin
          if (expire) begin
            sh <= {rxd_s, sh[9:1]};
            if (idx == LAST_IDX) begin
              done_q <= 1'b1;
              state  <= rxd_s ? RX_IDLE : RX_WAIT_HIGH;
            end else begin
              idx <= idx + 4'd1;
            end
          end
        end
        default: begin
          if (rxd_s) state <= RX_IDLE;
        end
      endcase
    end
  end

  assign frame_done = done_q;
  assign frame_data = sh[7:0];
  assign frame_b9   = sh[8];
  assign frame_stop = sh[9];

endmodule

// File: rtl/mp9_addr_filter.sv
module mp9_addr_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       filt_en,
  input  logic [7:0] my_addr,
  input  logic [7:0] addr_mask,
  input  logic       frame_done,
  input  logic [7:0] frame_data,
  input  logic       frame_b9,
  input  logic       frame_stop,
  output logic       accept,
  output logic       addressed
);

  logic good_frame;

  assign good_frame = frame_done & frame_stop;
  assign accept     = good_frame & (~filt_en | frame_b9 | addressed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addressed <= 1'b0;
    else if (!filt_en)
      addressed <= 1'b0;
    else if (good_frame && frame_b9)
      addressed <= mp9_pkg::addr_hit(frame_data, my_addr, addr_mask);
  end

endmodule

// File: rtl/mp9_uart.sv
module mp9_uart #(
  parameter int DIV_BASE = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbl_speed,
  input  logic       filt_en,
  input  logic [7:0] my_addr,
  input  logic [7:0] addr_mask,
  input  logic       tx_load,
  input  logic [7:0] tx_data,
  input  logic       tx_bit9,
  output logic       tx_busy,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       addressed
);

  localparam int CW = $clog2(2 * DIV_BASE);

  logic       fr_done;
  logic [7:0] fr_data;
  logic       fr_b9;
  logic       fr_stop;
  logic       fr_accept;

  mp9_tx #(.DIV_BASE(DIV_BASE), .CW(CW)) tx_i (
    .clk   (clk),
    .rst_n (rst_n),
    .dbl   (dbl_speed),
    .load  (tx_load),
    .data  (tx_data),
    .bit9  (tx_bit9),
    .busy  (tx_busy),
    .txd   (txd)
  );

  mp9_rx #(.DIV_BASE(DIV_BASE), .CW(CW)) rx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbl        (dbl_speed),
    .rxd        (rxd),
    .frame_done (fr_done),
    .frame_data (fr_data),
    .frame_b9   (fr_b9),
    .frame_stop (fr_stop)
  );

  mp9_addr_filter filt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .filt_en    (filt_en),
    .my_addr    (my_addr),
    .addr_mask  (addr_mask),
    .frame_done (fr_done),
    .frame_data (fr_data),
    .frame_b9   (fr_b9),
    .frame_stop (fr_stop),
    .accept     (fr_accept),
    .addressed  (addressed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
    end else begin
      rx_valid <= fr_accept;
      if (fr_accept) begin
        rx_data <= fr_data;
        rx_bit9 <= fr_b9;
      end
    end
  end

endmodule

// File: rtl/mp9_uart_sva.sv
module mp9_uart_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       filt_en,
  input logic [7:0] my_addr,
  input logic [7:0] addr_mask,
  input logic       tx_load,
  input logic       tx_busy,
  input logic       txd,
  input logic       frame_done,
  input logic [7:0] frame_data,
  input logic       frame_b9,
  input logic       frame_stop,
  input logic       rx_valid,
  input logic       addressed
);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r3_busy_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_load));

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r4_valid_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(frame_done));

  a_r5_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_stop |=> !rx_valid);

  a_r6_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    filt_en && !addressed && frame_done && !frame_b9 |=> !rx_valid);

  a_r7_addr_state: assert property (@(posedge clk) disable iff (!rst_n)
    filt_en && frame_done && frame_stop && frame_b9 |=>
      addressed == mp9_pkg::addr_hit($past(frame_data), $past(my_addr),
                                     $past(addr_mask)));

  a_r8_deliver: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_stop && (!filt_en || frame_b9 || addressed) |=> rx_valid);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |=> !addressed);

endmodule

bind mp9_uart mp9_uart_sva chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .filt_en    (filt_en),
  .my_addr    (my_addr),
  .addr_mask  (addr_mask),
  .tx_load    (tx_load),
  .tx_busy    (tx_busy),
  .txd        (txd),
  .frame_done (fr_done),
  .frame_data (fr_data),
  .frame_b9   (fr_b9),
  .frame_stop (fr_stop),
  .rx_valid   (rx_valid),
  .addressed  (addressed)
);

// File: tb/mp9_uart_tb_top.sv
`timescale 1ns/1ps
module mp9_uart_tb_top;

  localparam int DIVB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       filt_en = 1'b0;
  logic [7:0] my_addr = 8'h00;
  logic [7:0] addr_mask = 8'hFF;
  logic       tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_bit9 = 1'b0;
  logic       tx_busy;
  logic       txd;
  logic       rxd = 1'b1;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       addressed;

  int n_chk = 0;
  int n_fail = 0;
  int vcnt = 0;

  always #2.5 clk = ~clk;

  mp9_uart #(.DIV_BASE(DIVB)) dut_i (
    .clk(clk), .rst_n(rst_n), .dbl_speed(dbl_speed), .filt_en(filt_en),
    .my_addr(my_addr), .addr_mask(addr_mask), .tx_load(tx_load),
    .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .addressed(addressed)
  );

  always @(negedge clk) if (rst_n && rx_valid) vcnt++;

  function automatic int per(bit d);
    return d ? DIVB : 2 * DIVB;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1 R2 R3: transmit one frame and check every bit edge
  task automatic tx_frame(logic [7:0] d, logic b9, bit dsp);
    logic [10:0] exp_bits;
    int p;
    p = per(dsp);
    exp_bits = {1'b1, b9, d, 1'b0};
    dbl_speed = dsp;
    @(negedge clk);
    tx_data = d; tx_bit9 = b9; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk(tx_busy == 1'b1, "R3 busy after load", tx_busy, 1);
    for (int i = 0; i < 11; i++) begin
      for (int j = 0; j < p; j++) begin
        if (i == 0 && j == 3) begin
          tx_load = 1'b1; tx_data = ~d; tx_bit9 = ~b9;  // R3 load while busy
        end else begin
          tx_load = 1'b0;
        end
        if (j == 0 || j == p - 1)
          chk(txd == exp_bits[i], $sformatf("R1/R2 tx bit %0d cyc %0d", i, j),
              txd, exp_bits[i]);
        @(negedge clk);
      end
    end
    chk(tx_busy == 1'b0 && txd == 1'b1, "R3 idle after 11 bits",
        {tx_busy, txd}, 2'b01);
  endtask

  task automatic rx_drive(logic [7:0] d, logic b9, logic stop, bit dsp);
    logic [10:0] bits;
    int p;
    p = per(dsp);
    dbl_speed = dsp;
    bits = {stop, b9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = bits[i];
      repeat (p) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (3 * p) @(negedge clk);
  endtask

  task automatic rx_expect(logic [7:0] d, logic b9, logic stop, bit dsp,
                           bit deliver, string tag);
    int v0;
    logic [7:0] old_d;
    logic old_b9;
    v0 = vcnt; old_d = rx_data; old_b9 = rx_bit9;
    rx_drive(d, b9, stop, dsp);
    chk((vcnt - v0) == (deliver ? 1 : 0), {tag, " rx_valid count"},
        vcnt - v0, deliver ? 1 : 0);
    if (deliver) begin
      chk(rx_data == d, {tag, " rx_data"}, rx_data, d);
      chk(rx_bit9 == b9, {tag, " rx_bit9"}, rx_bit9, b9);
    end else begin
      chk(rx_data == old_d && rx_bit9 == old_b9, {tag, " outputs held"},
          {rx_bit9, rx_data}, {old_b9, old_d});
    end
  endtask

  initial begin
    logic [7:0] tv [7];
    tv = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(txd == 1'b1 && tx_busy == 1'b0, "R10 tx reset", {txd, tx_busy}, 2'b10);
    chk(rx_valid == 1'b0 && rx_data == 8'h00 && rx_bit9 == 1'b0,
        "R10 rx reset", {rx_valid, rx_bit9, rx_data}, 0);
    chk(addressed == 1'b0, "R10 addressed reset", addressed, 0);

    // R1 R2 R3 transmit sweep
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 7; k++)
        for (int b = 0; b < 2; b++)
          tx_frame(tv[k], b[0], s[0]);

    // R4 R2 unfiltered receive sweep at both rates
    filt_en = 1'b0;
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 256; v += 17)
        rx_expect(8'(v), v[0], 1'b1, s[0], 1'b1, "R4 open receive");

    // R5 bad stop bit
    rx_expect(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, "R5 bad stop");
    rx_expect(8'h3C, 1'b0, 1'b1, 1'b0, 1'b1, "R5 recovery");

    // R11 false start
    begin
      int v0;
      v0 = vcnt;
      rxd = 1'b0; @(negedge clk); rxd = 1'b1;
      repeat (15 * per(1'b0)) @(negedge clk);
      chk(vcnt == v0, "R11 glitch rejected", vcnt - v0, 0);
      rx_expect(8'h96, 1'b0, 1'b1, 1'b0, 1'b1, "R11 frame after glitch");
    end

    // R6 R7 R8 filtering with full mask
    filt_en = 1'b1; my_addr = 8'h42; addr_mask = 8'hFF;
    rx_expect(8'h11, 1'b0, 1'b1, 1'b0, 1'b0, "R6 data ignored");
    chk(addressed == 1'b0, "R6 not addressed", addressed, 0);
    rx_expect(8'h17, 1'b1, 1'b1, 1'b0, 1'b1, "R7 foreign address");
    chk(addressed == 1'b0, "R7 no match", addressed, 0);
    rx_expect(8'h22, 1'b0, 1'b1, 1'b0, 1'b0, "R6 data ignored again");
    rx_expect(8'h42, 1'b1, 1'b1, 1'b0, 1'b1, "R7 own address");
    chk(addressed == 1'b1, "R7 match", addressed, 1);
    rx_expect(8'h99, 1'b0, 1'b1, 1'b0, 1'b1, "R8 data accepted");
    rx_expect(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R8 data accepted fast");
    rx_expect(8'h43, 1'b1, 1'b1, 1'b0, 1'b1, "R7 other address");
    chk(addressed == 1'b0, "R7 deselected", addressed, 0);
    rx_expect(8'h55, 1'b0, 1'b1, 1'b0, 1'b0, "R6 data after deselect");

    // R7 masked compare, exhaustive over the address byte
    my_addr = 8'h40; addr_mask = 8'hF0;
    for (int v = 0; v < 256; v++) begin
      bit hit;
      hit = ((8'(v) ^ 8'h40) & 8'hF0) == 8'h00;
      rx_expect(8'(v), 1'b1, 1'b1, 1'b1, 1'b1, "R7 mask sweep");
      chk(addressed == hit, $sformatf("R7 mask match %02h", v), addressed, hit);
    end
    rx_expect(8'h77, 1'b0, 1'b1, 1'b1, 1'b0, "R6 after last miss");

    // R9 disabling the filter
    rx_expect(8'h4E, 1'b1, 1'b1, 1'b1, 1'b1, "R9 select");
    chk(addressed == 1'b1, "R9 selected", addressed, 1);
    filt_en = 1'b0;
    @(negedge clk);
    chk(addressed == 1'b0, "R9 cleared next edge", addressed, 0);
    rx_expect(8'hE1, 1'b0, 1'b1, 1'b1, 1'b1, "R9 open accept");
    filt_en = 1'b1;
    rx_expect(8'hE2, 1'b0, 1'b1, 1'b1, 1'b0, "R9 stays deselected");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule